// File: doc/BRIEF.md
# Memory cycle wait-state inserter

This block times the ready indication for local DRAM cycles and external cache cycles. It holds two configuration bytes: a cache control byte and a memory control byte. From these bytes it decodes how many extra clocks each kind of cycle needs. Each cycle begins with a one-clock start pulse, which carries a direction flag and a target flag. When the decoded number of wait states has elapsed, the block answers with a single-clock ready pulse.

The two DRAM directions use different encodings:

- **Write:** the write field is a plain binary count.
- **Read:** the read field is offset by one. Its unused zero code is treated as the slowest setting, two wait states.

Cache writes take one wait state unless the fast-write bit is set. Cache reads always complete without wait states. While the cache enable bit is clear, a cycle aimed at the cache is timed as a DRAM cycle. The wait count is captured when a cycle is accepted. A start that arrives while a cycle is still counting is dropped.

Top module: `mem_wait_gen`

## Requirements
- R1: After synchronous reset, ready is low and both configuration bytes are zero. The cache control byte reads 0x00 and the memory control byte reads 0x0F.
- R2: Reading the memory control byte (cfg_sel=1) returns 1 in bits 3:0 whatever was written. Bits 7:4 return the last written value. The cache control byte (cfg_sel=0) reads back as written.
- R3: A DRAM write waits for the number of clocks in memory control bits 5:4: 00→0, 01→1, 10→2, 11→3.
- R4: A DRAM read waits according to memory control bits 7:6: 01→0, 10→1, 11→2. Code 00 also gives 2.
- R5: With the cache enabled, a cache write waits 1 clock when cache control bit 0 is 0. It waits 0 clocks when that bit is 1.
- R6: With the cache enabled, a cache read waits 0 clocks.
- R7: Cache control bit 4 enables the cache. While it is 0, a cycle with cyc_cache=1 is timed exactly as a DRAM cycle of the same direction.
- R8: Ready is high for exactly one clock, N+1 clocks after the edge that samples an accepted start, where N is the decoded wait count.
- R9: A start that is sampled before the ready of the running cycle has no effect. A start sampled while ready is high is accepted as a new cycle.
- R10: The wait count is fixed when a cycle is accepted. Configuration writes made while that cycle counts do not change its ready time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the selected configuration byte |
| cfg_sel | input | 1 | 0 selects the cache control byte, 1 selects the memory control byte |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Readback of the selected configuration byte |
| cyc_start | input | 1 | One-clock pulse that begins a memory cycle |
| cyc_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| cyc_cache | input | 1 | 1 when the cycle targets the external cache, 0 for DRAM |
| ready | output | 1 | One-clock pulse that ends the cycle |

## Verification
A wrong count load or a wrong decode shows up as ready arriving early or late. The error is visible within at most four clocks of the start pulse, because the bench measures the latency of every cycle against its own decode of the two bytes.

A busy flag that clears too soon shows up as a second ready after a dropped start. A busy flag that never clears shows up as a missing ready. Either is seen within a few clocks of the first ready.

A corrupted configuration store shows up immediately on cfg_rdata. It also shows up as mistimed cycles in the randomized sweep.

// File: rtl/mwg_pkg.sv
package mwg_pkg;
    localparam int CFG_W = 8;
    localparam int CNT_W = 2;

    typedef logic [CNT_W-1:0] wait_t;

    typedef enum logic {TGT_DRAM = 1'b0, TGT_CACHE = 1'b1} target_e;

    typedef struct packed {
        logic [1:0] rd_code;
        logic [1:0] wr_code;
    } mem_fields_t;

    typedef struct packed {
        logic       cache_en;
        logic       wr_fast;
    } cache_fields_t;

    function automatic wait_t dram_rd_wait(input logic [1:0] code);
        if (code == 2'b00) return wait_t'(2);
        return wait_t'(code - 2'b01);
    endfunction

    function automatic wait_t dram_wr_wait(input logic [1:0] code);
        return wait_t'(code);
    endfunction

    function automatic wait_t cache_wr_wait(input logic fast);
        return fast ? wait_t'(0) : wait_t'(1);
    endfunction
endpackage

// File: rtl/mwg_cfg_regs.sv
module mwg_cfg_regs
    import mwg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output cache_fields_t    cache_f,
    output mem_fields_t      mem_f
);
    localparam int HALF = CFG_W / 2;

    logic [CFG_W-1:0] cache_byte;
    logic [HALF-1:0]  mem_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            cache_byte <= '0;
            mem_hi     <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) mem_hi     <= cfg_wdata[CFG_W-1:HALF];
            else         cache_byte <= cfg_wdata;
        end
    end

    always_comb begin
        cfg_rdata = cfg_sel ? {mem_hi, {HALF{1'b1}}} : cache_byte;
        cache_f   = '{cache_en: cache_byte[4], wr_fast: cache_byte[0]};
        mem_f     = '{rd_code: mem_hi[3:2], wr_code: mem_hi[1:0]};
    end

    p_low_ones_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_sel |-> cfg_rdata[HALF-1:0] == {HALF{1'b1}});
endmodule

// File: rtl/mwg_wait_decode.sv
module mwg_wait_decode
    import mwg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  cache_fields_t cache_f,
    input  mem_fields_t   mem_f,
    input  logic          cyc_write,
    input  target_e       target,
    output wait_t         n_wait
);
    logic use_cache;

    always_comb begin
        use_cache = (target == TGT_CACHE) && cache_f.cache_en;
        if (use_cache)
            n_wait = cyc_write ? cache_wr_wait(cache_f.wr_fast) : '0;
        else
            n_wait = cyc_write ? dram_wr_wait(mem_f.wr_code)
                               : dram_rd_wait(mem_f.rd_code);
    end

    p_cache_rd_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (use_cache && !cyc_write) |-> n_wait == '0);
    p_rd_floor_r4: assert property (@(posedge clk) disable iff (rst)
        (!use_cache && !cyc_write && mem_f.rd_code != 2'b01) |-> n_wait != '0);
endmodule

// File: rtl/mwg_wait_counter.sv
module mwg_wait_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] n_wait,
    output logic             ready
);
    logic             busy;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            ready <= 1'b0;
        end else begin
            ready <= 1'b0;
            if (busy) begin
                if (cnt == '0) begin
                    ready <= 1'b1;
                    busy  <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (start) begin
                busy <= 1'b1;
                cnt  <= n_wait;
            end
        end
    end

    p_ready_due_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == '0) |=> ready);
    p_ready_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);
    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> (busy && cnt == CNT_W'($past(cnt) - 1'b1)));
    p_capture_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && cnt == $past(n_wait)));
endmodule

// File: rtl/mem_wait_gen.sv
module mem_wait_gen
    import mwg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             cyc_start,
    input  logic             cyc_write,
    input  logic             cyc_cache,
    output logic             ready
);
    cache_fields_t cache_f;
    mem_fields_t   mem_f;
    wait_t         n_wait;
    target_e       target;

    assign target = cyc_cache ? TGT_CACHE : TGT_DRAM;

    mwg_cfg_regs u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cache_f(cache_f), .mem_f(mem_f)
    );

    mwg_wait_decode u_dec (
        .clk(clk), .rst(rst), .cache_f(cache_f), .mem_f(mem_f),
        .cyc_write(cyc_write), .target(target), .n_wait(n_wait)
    );

    mwg_wait_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .start(cyc_start),
        .n_wait(n_wait), .ready(ready)
    );
endmodule

// File: tb/mem_wait_gen_bench.sv
module mem_wait_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       cyc_start = 1'b0, cyc_write = 1'b0, cyc_cache = 1'b0;
    logic       ready;

    int tests = 0, fails = 0;
    logic [7:0] sh_cache = '0, sh_mem = '0;

    always #4 clk = ~clk;

    mem_wait_gen u_mem_wait_gen (.*);

    function automatic int exp_wait(logic [7:0] cb, logic [7:0] mb, logic wr, logic ca);
        if (ca && cb[4]) return wr ? (cb[0] ? 0 : 1) : 0;
        if (wr) return int'(mb[5:4]);
        return (mb[7:6] == 2'b00) ? 2 : int'(mb[7:6]) - 1;
    endfunction

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic sel, logic [7:0] d);
        cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (sel) sh_mem = d; else sh_cache = d;
    endtask

    // Issues a start and returns the clocks until ready (99 if none within 8).
    task automatic run_cycle(logic wr, logic ca, output int lat);
        cyc_write = wr; cyc_cache = ca; cyc_start = 1'b1;
        @(posedge clk); #1;
        cyc_start = 1'b0;
        lat = 99;
        for (int i = 1; i <= 8; i++) begin
            @(posedge clk); #1;
            if (ready) begin lat = i; break; end
        end
    endtask

    task automatic quiet_after(string req, int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (ready) seen++;
        end
        check(req, seen, 0);
    endtask

    initial begin
        #1_000_000;
        fails++; tests++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        check("R1 ready", int'(ready), 0);
        cfg_sel = 1'b0; #1 check("R1 cache byte", int'(cfg_rdata), 8'h00);
        cfg_sel = 1'b1; #1 check("R1 mem byte", int'(cfg_rdata), 8'h0F);
        run_cycle(1'b0, 1'b0, lat);
        check("R1 R4 reset read code 00", lat, 3);

        // R2 readback
        cfg_write(1'b1, 8'hA0); #1 check("R2 mem readback", int'(cfg_rdata), 8'hAF);
        cfg_write(1'b1, 8'h50); #1 check("R2 mem low ones", int'(cfg_rdata), 8'h5F);
        cfg_write(1'b0, 8'h3C); cfg_sel = 1'b0; #1 check("R2 cache readback", int'(cfg_rdata), 8'h3C);

        // R3 all write codes, R4 all read codes
        for (int c = 0; c < 4; c++) begin
            cfg_write(1'b1, 8'(c << 4));
            run_cycle(1'b1, 1'b0, lat);
            check("R3 dram write", lat, c + 1);
            quiet_after("R8 single pulse", 2);
            cfg_write(1'b1, 8'(c << 6));
            run_cycle(1'b0, 1'b0, lat);
            check("R4 dram read", lat, ((c == 0) ? 2 : c - 1) + 1);
        end

        // R5 / R6 cache enabled
        cfg_write(1'b1, 8'hF0);
        cfg_write(1'b0, 8'h10);
        run_cycle(1'b1, 1'b1, lat); check("R5 cache write slow", lat, 2);
        cfg_write(1'b0, 8'h11);
        run_cycle(1'b1, 1'b1, lat); check("R5 cache write fast", lat, 1);
        run_cycle(1'b0, 1'b1, lat); check("R6 cache read", lat, 1);

        // R7 cache disabled -> DRAM timing
        cfg_write(1'b0, 8'h01);
        run_cycle(1'b1, 1'b1, lat); check("R7 disabled cache write", lat, 4);
        run_cycle(1'b0, 1'b1, lat); check("R7 disabled cache read", lat, 3);

        // R9 start while counting is ignored
        cfg_write(1'b1, 8'h30);
        cyc_write = 1'b1; cyc_cache = 1'b0; cyc_start = 1'b1;
        @(posedge clk); #1 cyc_start = 1'b0;
        @(posedge clk); #1 cyc_start = 1'b1;
        @(posedge clk); #1 cyc_start = 1'b0;
        lat = 99;
        for (int i = 3; i <= 8; i++) begin
            @(posedge clk); #1;
            if (ready) begin lat = i; break; end
        end
        check("R9 first ready", lat, 4);
        quiet_after("R9 no ready from dropped start", 6);

        // R9 start during ready accepted (back-to-back)
        run_cycle(1'b1, 1'b0, lat);
        check("R9 lead cycle", lat, 4);
        cyc_start = 1'b1;
        @(posedge clk); #1 cyc_start = 1'b0;
        lat = 99;
        for (int i = 1; i <= 8; i++) begin
            @(posedge clk); #1;
            if (ready) begin lat = i; break; end
        end
        check("R9 start at ready accepted", lat, 4);

        // R10 config change mid-cycle
        cyc_write = 1'b1; cyc_cache = 1'b0; cyc_start = 1'b1;
        @(posedge clk); #1 cyc_start = 1'b0;
        cfg_write(1'b1, 8'h00);
        lat = 99;
        for (int i = 2; i <= 8; i++) begin
            @(posedge clk); #1;
            if (ready) begin lat = i; break; end
        end
        check("R10 captured count", lat, 4);

        // Random sweep, R3..R8
        void'($urandom(32'h5EED_1234));
        for (int k = 0; k < 60; k++) begin
            logic wr, ca;
            cfg_write(1'b0, 8'($urandom));
            cfg_write(1'b1, 8'($urandom));
            wr = 1'($urandom); ca = 1'($urandom);
            run_cycle(wr, ca, lat);
            check("R8 random latency", lat, exp_wait(sh_cache, sh_mem, wr, ca) + 1);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule